// File: doc/BRIEF.md
# Stereo Audio Sample Feeder

This block feeds a pair of oversampling converter channels, left and right, with 16-bit sample words. Software or a DMA engine writes samples over a simple register-write bus into a four-word queue per channel. Once per output period, which is a fixed number of ticks of a programmable divided converter clock, both channels take one word from their queues together. A channel whose queue is empty at that moment gets a programmable fallback word, and its queue is left untouched.

After each such take, and when the block is switched on, every channel raises a one-cycle data request. A per-channel mode bit decides whether the request means "queue empty" or "queue has room". Full and empty flags are visible at all times. A low-power request switches the block off. Depending on a retain bit, it then either clears the queues and the timing counters or keeps everything frozen so that a later restart continues mid-period.

Top module: `stereo_feed_ctrl`

## Requirements
- R1: After reset the block is off, both queues are empty and not full, no request or sample strobe is active, both sample outputs are 0, and the divider field holds 5 (divide by 6).
- R2: A write to address 3 (left) or address 4 (right) while the block is on appends the word to that channel's four-word queue. Words leave in write order. Full is 1 when four words are held. Full and empty are never both 1.
- R3: A write to a channel whose queue is full is discarded.
- R4: A write to a channel queue while the block is off is discarded.
- R5: The control word is at address 0: bit 0 is on, bit 1 is retain, and bits 14:8 are the divider field D. While the block is on, the converter tick fires once every D+1 clock cycles and a take happens every 256 ticks. Each take is shown one cycle later by a one-cycle sample strobe together with the new sample words.
- R6: A channel whose queue is empty at a take outputs the fallback word, which is written at address 2. Its queue does not change.
- R7: Address 1 bits 0 (left) and 1 (right) pick the request mode: 1 requests when the queue is empty after the take, 0 requests when it is not full. The request is a one-cycle pulse aligned with the sample strobe.
- R8: On switch-on, every channel evaluates its request condition in the cycle after the on state starts, with no sample strobe. A start from cleared state loads the fallback word into both sample outputs, and that word stands for the first period.
- R9: A low-power request turns the block off. With retain at 0 it empties both queues and restarts the period timing, while the fallback word, the request modes and the divider are kept.
- R10: With retain at 1, a low-power request turns the block off but keeps the queue contents, the sample outputs and the position inside the period. After the block is switched on again, the next take comes once the remaining enabled cycles of that period have passed.
- R11: A switch-on write and a low-power request in the same cycle leave the block off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 request modes, 2 fallback, 3 left data, 4 right data) |
| wrData | input | 16 | Write data |
| lowPowerReq | input | 1 | Sleep or stop request, one cycle |
| running | output | 1 | Block is switched on |
| convTick | output | 1 | Divided converter clock enable |
| sampleValid | output | 1 | One-cycle strobe after each take |
| sampleLeft | output | 16 | Current left channel word |
| sampleRight | output | 16 | Current right channel word |
| reqLeft | output | 1 | Left data request pulse |
| reqRight | output | 1 | Right data request pulse |
| fullLeft | output | 1 | Left queue full |
| emptyLeft | output | 1 | Left queue empty |
| fullRight | output | 1 | Right queue full |
| emptyRight | output | 1 | Right queue empty |

## Verification
The hardest case to reach is a retained sleep in the middle of a period: the divider and period counters must freeze and then continue, and nothing at the ports shows their position. The stimulus places the sleep about a hundred cycles after a take, holds the block off for several hundred cycles, and switches it back on. The bench then counts only the cycles in which the block is on between two sample strobes, so a counter that restarts or drifts changes that count. Cleared sleep and a switch-on that collides with a sleep request follow in the same run. The bench writes only just after a strobe, so its queue model never has to resolve a write that lands in the same cycle as a take.

// File: rtl/feed_pkg.sv
package feed_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    ADDR_CTRL    = 3'd0,
    ADDR_REQTYPE = 3'd1,
    ADDR_DEFAULT = 3'd2,
    ADDR_LEFT    = 3'd3,
    ADDR_RIGHT   = 3'd4
  } feedAddr_t;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic [NUM_CH-1:0] push;      // accepted-candidate write per channel
    logic              popTick;   // period boundary: take one word per channel
    logic              evalTick;  // evaluate request condition this cycle
    logic              freshLoad; // start from cleared state: load fallback word
    logic              flush;     // empty the queues
  } feedStrobe_t;

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/feed_ctrl.sv
module feed_ctrl
  import feed_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DIV_W     = 7,
  parameter int OSR       = 256,
  parameter int DIV_RESET = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lowPowerReq,
  output feedStrobe_t       strobe,
  output logic [NUM_CH-1:0] reqType,
  output logic [DATA_W-1:0] defaultWord,
  output logic              running,
  output logic              convTick
);

  localparam int EN_BIT   = 0;
  localparam int HOLD_BIT = 1;
  localparam int DIV_LSB  = 8;
  localparam int PER_W    = (OSR > 1) ? $clog2(OSR) : 1;

  logic              enReg, enPrev, holdReg, freshReg, evalReg;
  logic [DIV_W-1:0]  divSel, divCnt;
  logic [PER_W-1:0]  periodCnt;
  logic [NUM_CH-1:0] reqTypeReg;
  logic [DATA_W-1:0] dfltReg;

  logic ctrlWr, typeWr, dfltWr;
  logic divTick, lastSlot, popNow, startNow, flushNow;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign typeWr   = wrEn && (wrAddr == ADDR_REQTYPE);
  assign dfltWr   = wrEn && (wrAddr == ADDR_DEFAULT);

  assign divTick  = enReg && (divCnt >= divSel);
  assign lastSlot = (periodCnt == PER_W'(OSR - 1));
  assign popNow   = divTick && lastSlot;
  assign startNow = enReg && !enPrev && !lowPowerReq;
  assign flushNow = lowPowerReq && !holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      enPrev     <= 1'b0;
      holdReg    <= 1'b0;
      freshReg   <= 1'b1;
      evalReg    <= 1'b0;
      divSel     <= DIV_W'(DIV_RESET);
      divCnt     <= '0;
      periodCnt  <= '0;
      reqTypeReg <= '0;
      dfltReg    <= '0;
    end else begin
      if (ctrlWr) begin
        enReg   <= wrData[EN_BIT];
        holdReg <= wrData[HOLD_BIT];
        divSel  <= wrData[DIV_LSB +: DIV_W];
      end
      if (lowPowerReq) enReg <= 1'b0;   // sleep wins over a same-cycle switch-on
      if (typeWr) reqTypeReg <= wrData[NUM_CH-1:0];
      if (dfltWr) dfltReg    <= wrData;

      enPrev  <= enReg;
      evalReg <= popNow || startNow;

      if (flushNow)      freshReg <= 1'b1;
      else if (startNow) freshReg <= 1'b0;

      if (flushNow) begin
        divCnt    <= '0;
        periodCnt <= '0;
      end else if (enReg) begin
        if (divTick) begin
          divCnt    <= '0;
          periodCnt <= lastSlot ? '0 : periodCnt + 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_push
      localparam feedAddr_t CH_ADDR = (ch == 0) ? ADDR_LEFT : ADDR_RIGHT;
      assign strobe.push[ch] = wrEn && enReg && (wrAddr == CH_ADDR);
    end
  endgenerate

  assign strobe.popTick   = popNow;
  assign strobe.evalTick  = evalReg;
  assign strobe.freshLoad = startNow && freshReg;
  assign strobe.flush     = flushNow;

  assign reqType     = reqTypeReg;
  assign defaultWord = dfltReg;
  assign running     = enReg;
  assign convTick    = divTick;

endmodule

// File: rtl/feed_datapath.sv
module feed_datapath
  import feed_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  feedStrobe_t                   strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W-1:0]             defaultWord,
  input  logic [NUM_CH-1:0]             reqType,
  output logic [NUM_CH-1:0][DATA_W-1:0] sample,
  output logic                          sampleValid,
  output logic [NUM_CH-1:0]             req,
  output logic [NUM_CH-1:0]             full,
  output logic [NUM_CH-1:0]             empty
);

  always_ff @(posedge clk) begin
    if (!rstN) sampleValid <= 1'b0;
    else       sampleValid <= strobe.popTick;
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [DATA_W-1:0] headWord, curWord;
      logic              isFull, isEmpty;

      chan_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rstN  (rstN),
        .push  (strobe.push[ch]),
        .pop   (strobe.popTick),
        .flush (strobe.flush),
        .din   (wrData),
        .head  (headWord),
        .full  (isFull),
        .empty (isEmpty)
      );

      // Fallback substitution sits at the output register, not in the queue
      always_ff @(posedge clk) begin
        if (!rstN)                  curWord <= '0;
        else if (strobe.popTick)    curWord <= isEmpty ? defaultWord : headWord;
        else if (strobe.freshLoad)  curWord <= defaultWord;
      end

      assign sample[ch] = curWord;
      assign full[ch]   = isFull;
      assign empty[ch]  = isEmpty;
      assign req[ch]    = strobe.evalTick && (reqType[ch] ? isEmpty : !isFull);
    end
  endgenerate

endmodule

// File: rtl/stereo_feed_ctrl.sv
module stereo_feed_ctrl
  import feed_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 7,
  parameter int OSR        = 256,
  parameter int DIV_RESET  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lowPowerReq,
  output logic              running,
  output logic              convTick,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleLeft,
  output logic [DATA_W-1:0] sampleRight,
  output logic              reqLeft,
  output logic              reqRight,
  output logic              fullLeft,
  output logic              emptyLeft,
  output logic              fullRight,
  output logic              emptyRight
);

  feedStrobe_t                   strobe;
  logic [NUM_CH-1:0]             reqType;
  logic [DATA_W-1:0]             defaultWord;
  logic [NUM_CH-1:0][DATA_W-1:0] sample;
  logic [NUM_CH-1:0]             req, full, empty;

  feed_ctrl #(
    .DATA_W    (DATA_W),
    .DIV_W     (DIV_W),
    .OSR       (OSR),
    .DIV_RESET (DIV_RESET)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .lowPowerReq (lowPowerReq),
    .strobe      (strobe),
    .reqType     (reqType),
    .defaultWord (defaultWord),
    .running     (running),
    .convTick    (convTick)
  );

  feed_datapath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .defaultWord (defaultWord),
    .reqType     (reqType),
    .sample      (sample),
    .sampleValid (sampleValid),
    .req         (req),
    .full        (full),
    .empty       (empty)
  );

  assign sampleLeft  = sample[0];
  assign sampleRight = sample[1];
  assign reqLeft     = req[0];
  assign reqRight    = req[1];
  assign fullLeft    = full[0];
  assign emptyLeft   = empty[0];
  assign fullRight   = full[1];
  assign emptyRight  = empty[1];

endmodule

// File: rtl/stereo_feed_chk.sv
module stereo_feed_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lowPowerReq,
  input logic              running,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleLeft,
  input logic [DATA_W-1:0] sampleRight,
  input logic              reqLeft,
  input logic              reqRight,
  input logic              fullLeft,
  input logic              emptyLeft,
  input logic              fullRight,
  input logic              emptyRight,
  input logic [DATA_W-1:0] defaultWord
);

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(fullLeft && emptyLeft) && !(fullRight && emptyRight));

  p_no_push_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!running && emptyLeft && emptyRight) |=> (emptyLeft && emptyRight));

  p_take_when_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(running));

  p_fallback_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && $past(emptyLeft)) |-> (sampleLeft == $past(defaultWord)));

  p_fallback_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && $past(emptyRight)) |-> (sampleRight == $past(defaultWord)));

  p_req_origin_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqLeft || reqRight) |-> $past(running));

  p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerReq |=> !running);

  p_frozen_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !lowPowerReq) |=>
      ($stable(emptyLeft) && $stable(fullLeft) && $stable(emptyRight) && $stable(fullRight)));

endmodule

bind stereo_feed_ctrl stereo_feed_chk #(.DATA_W(DATA_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .lowPowerReq (lowPowerReq),
  .running     (running),
  .sampleValid (sampleValid),
  .sampleLeft  (sampleLeft),
  .sampleRight (sampleRight),
  .reqLeft     (reqLeft),
  .reqRight    (reqRight),
  .fullLeft    (fullLeft),
  .emptyLeft   (emptyLeft),
  .fullRight   (fullRight),
  .emptyRight  (emptyRight),
  .defaultWord (defaultWord)
);

// File: tb/stereo_feed_ctrl_test.sv
`timescale 1ns/1ps
module stereo_feed_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        lowPowerReq = 1'b0;
  logic        running, convTick, sampleValid;
  logic [15:0] sampleLeft, sampleRight;
  logic        reqLeft, reqRight, fullLeft, emptyLeft, fullRight, emptyRight;

  always #2 clk = ~clk;

  stereo_feed_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lowPowerReq(lowPowerReq), .running(running), .convTick(convTick),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .reqLeft(reqLeft), .reqRight(reqRight), .fullLeft(fullLeft), .emptyLeft(emptyLeft),
    .fullRight(fullRight), .emptyRight(emptyRight)
  );

  int checks = 0, errors = 0;

  // Model state (owned by the single initial block and its forked branches)
  logic [15:0] qLeft[$], qRight[$];
  logic [15:0] mDflt = '0;
  logic [1:0]  mType = '0;
  bit          mEn = 0, mHold = 0, mFresh = 1;
  int          mDiv = 5, expPeriod = 1536;
  int          restartId = 0, skipId = 0;
  int          strobeCount = 0, startReqL = 0, startReqR = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic applyModel(input logic [2:0] a, input logic [15:0] d);
    case (a)
      3'd0: begin
        int nd = int'(d[14:8]);
        if (mEn && d[0] && nd != mDiv) skipId++;
        if (d[0] && !mEn && mFresh) begin restartId++; mFresh = 0; end
        mEn = d[0]; mHold = d[1]; mDiv = nd; expPeriod = 256 * (nd + 1);
      end
      3'd1: mType = d[1:0];
      3'd2: mDflt = d;
      3'd3: if (mEn && qLeft.size() < 4) qLeft.push_back(d);
      3'd4: if (mEn && qRight.size() < 4) qRight.push_back(d);
      default: ;
    endcase
  endtask

  task automatic sleepModel();
    mEn = 0;
    if (!mHold) begin
      qLeft.delete(); qRight.delete();
      mFresh = 1; skipId++;
    end
  endtask

  // Driver: one bus write, expected state pushed into the model queues
  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1 applyModel(a, d);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseSleep();
    @(negedge clk); lowPowerReq = 1'b1;
    @(posedge clk); #1 sleepModel();
    @(negedge clk); lowPowerReq = 1'b0;
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!sampleValid);
  endtask

  // Monitor: pops expected words and compares at each sample strobe
  task automatic monitor();
    int runCount = 0, lastRestart = 0, lastSkip = 0;
    bit skipNext = 0;
    forever begin
      @(negedge clk);
      if (skipId != lastSkip) begin skipNext = 1; lastSkip = skipId; end
      if (restartId != lastRestart) begin runCount = 0; skipNext = 0; lastRestart = restartId; end
      if (sampleValid) begin
        logic [15:0] eL, eR;
        strobeCount++;
        if (!skipNext) check("R5 take period in enabled cycles", runCount, expPeriod);
        skipNext = 0; runCount = 0;
        if (qLeft.size() > 0) begin eL = qLeft.pop_front();  check("R2 left order", sampleLeft, eL); end
        else begin eL = mDflt; check("R6 left fallback", sampleLeft, eL); end
        if (qRight.size() > 0) begin eR = qRight.pop_front(); check("R2 right order", sampleRight, eR); end
        else begin eR = mDflt; check("R6 right fallback", sampleRight, eR); end
        check("R7 left request", reqLeft,  mType[0] ? (qLeft.size() == 0)  : (qLeft.size() < 4));
        check("R7 right request", reqRight, mType[1] ? (qRight.size() == 0) : (qRight.size() < 4));
      end else begin
        if (reqLeft)  startReqL++;
        if (reqRight) startReqR++;
      end
      if (running) runCount++;
    end
  endtask

  initial begin
    int savedStrobes, savedL, savedR;
    logic [15:0] savedSample;
    fork
      monitor();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 running", running, 0);
    check("R1 empty", {emptyLeft, emptyRight}, 2'b11);
    check("R1 full", {fullLeft, fullRight}, 2'b00);
    check("R1 request/strobe", {reqLeft, reqRight, sampleValid, convTick}, 0);
    check("R1 samples", {sampleLeft, sampleRight}, 0);

    busWrite(3'd2, 16'h8000);
    busWrite(3'd1, 16'h0001);   // left: empty mode, right: not-full mode
    busWrite(3'd3, 16'h1111);   // discarded, block off
    @(negedge clk);
    check("R4 write while off", emptyLeft, 1);

    busWrite(3'd0, 16'h0501);   // on, divider reset value kept (divide by 6)
    repeat (3) @(negedge clk);
    check("R8 start request left", startReqL, 1);
    check("R8 start request right", startReqR, 1);
    check("R8 fresh fallback left", sampleLeft, 16'h8000);
    check("R8 fresh fallback right", sampleRight, 16'h8000);
    waitStrobe();               // first period of 1536 checked by monitor

    busWrite(3'd0, 16'h0001);   // divide by 1
    for (int i = 0; i < 5; i++) busWrite(3'd3, 16'hA000 + 16'(i));
    busWrite(3'd4, 16'hB000);
    busWrite(3'd4, 16'hB001);
    @(negedge clk);
    check("R2 left full", fullLeft, 1);
    check("R2 right partial", {fullRight, emptyRight}, 2'b00);
    repeat (6) waitStrobe();
    @(negedge clk);
    check("R3 fifth word discarded", emptyLeft, 1);

    busWrite(3'd0, 16'h0101);   // divide by 2
    begin
      int n = 0;
      do @(negedge clk); while (!convTick);
      do begin @(negedge clk); n++; end while (!convTick);
      check("R5 tick spacing", n, 2);
    end
    repeat (2) waitStrobe();

    // R10 retained sleep mid-period
    busWrite(3'd0, 16'h0103);
    busWrite(3'd3, 16'hC000);
    busWrite(3'd3, 16'hC001);
    busWrite(3'd3, 16'hC002);
    waitStrobe();
    repeat (100) @(negedge clk);
    savedStrobes = strobeCount; savedSample = sampleLeft;
    pulseSleep();
    check("R10 off after sleep", running, 0);
    check("R10 queue kept", {emptyLeft, fullLeft}, 2'b00);
    repeat (600) @(negedge clk);
    check("R10 no take while off", strobeCount, savedStrobes);
    check("R10 sample kept", sampleLeft, savedSample);
    savedL = startReqL; savedR = startReqR;
    busWrite(3'd0, 16'h0103);
    repeat (3) @(negedge clk);
    check("R8 resume request left", startReqL, savedL);
    check("R8 resume request right", startReqR, savedR + 1);
    check("R10 no fallback reload", sampleLeft, savedSample);
    waitStrobe();               // remaining period checked by monitor

    // R9 cleared sleep
    busWrite(3'd0, 16'h0101);
    busWrite(3'd3, 16'hD000);
    pulseSleep();
    check("R9 off after sleep", running, 0);
    check("R9 queues cleared", {emptyLeft, emptyRight}, 2'b11);
    savedL = startReqL; savedR = startReqR;
    busWrite(3'd0, 16'h0101);
    repeat (3) @(negedge clk);
    check("R9 fallback word kept", sampleLeft, 16'h8000);
    check("R8 fresh request left", startReqL, savedL + 1);
    check("R8 fresh request right", startReqR, savedR + 1);
    waitStrobe();

    // R11 switch-on and sleep together
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 16'h0101; lowPowerReq = 1'b1;
    @(posedge clk); #1 applyModel(3'd0, 16'h0101); sleepModel();
    @(negedge clk); wrEn = 1'b0; lowPowerReq = 1'b0;
    check("R11 sleep wins", running, 0);
    savedStrobes = strobeCount;
    repeat (1100) @(negedge clk);
    check("R11 stays off", strobeCount, savedStrobes);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule